// File: doc/BRIEF.md
# Floating-Point Compare-to-Flags Unit

The unit compares two 80-bit extended-precision operands: the register-stack top and a stack register selected by the opcode. It writes the outcome directly as integer condition flags, so a conditional branch or conditional move can use the result with no transfer through a status word. Four variants are decoded from a two-byte opcode. The signalling compare and the quiet (unordered) compare each come with or without a single pop of the register stack.

A compare is launched by a one-cycle start strobe, which carries the opcode, both operands and their empty tags. One cycle later the unit pulses done and presents the flags, an invalid-operand indication, a request to clear status bit C1 on stack underflow, and a pop request. The invalid and C1 outputs are asserted only when an exception arises. The flag outputs hold their value between compares. The register stack, trap delivery and branch logic sit outside the unit.

Top module: `fcf_unit`

## Requirements
- R1: done_o pulses high exactly one cycle after a start_i cycle whose opcode is recognised. The first byte opcode_i[15:8] must be 8'hDB (no pop) or 8'hDF (pop). The second byte's upper five bits opcode_i[7:3] must be 5'b11110 (signalling) or 5'b11101 (quiet). A start with any other opcode produces no done pulse, and the flags, invalid and pop outputs keep their previous values.
- R2: flags_o is {ZF,PF,CF}. The encodings are greater 3'b000, less 3'b001, equal 3'b100 and unordered 3'b111. For ordered operands of equal sign, the magnitude is compared by biased exponent (bits 78:64) first and then by the 64-bit significand (bits 63:0). The ordering is reversed when both operands are negative (bit 79 set).
- R3: When the signs differ and the operands are not both zero, the positive operand is greater. A positive zero and a negative zero compare equal.
- R4: In the signalling variants, any NaN operand gives unordered with invalid_o=1. A NaN has exponent 15'h7FFF, bit 63 set and bits 62:0 nonzero.
- R5: In the quiet variants, a quiet NaN (bit 62 set) gives unordered with invalid_o=0. A signalling NaN (bit 62 clear) gives unordered with invalid_o=1.
- R6: In every variant, an operand with a nonzero exponent and bit 63 clear is an unsupported encoding. Such an operand gives unordered with invalid_o=1.
- R7: When either empty tag is set, the result is unordered with invalid_o=1 and c1_clr_o=1. c1_clr_o is 0 in every other case.
- R8: pop_o pulses with done_o only for the 8'hDF variants. It is suppressed when invalid_o is raised while inv_mask_i was 0 at start.
- R9: src_idx_o always equals opcode_i[2:0], the index of the stack register compared against the top.
- R10: After reset, done_o, flags_o, invalid_o, c1_clr_o and pop_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch a compare this cycle |
| opcode_i | input | 16 | Two-byte opcode, first byte in 15:8 |
| src_idx_o | output | 3 | Selected stack register index |
| top_i | input | 80 | Stack-top operand |
| sti_i | input | 80 | Selected-register operand |
| top_empty_i | input | 1 | Stack top tagged empty |
| sti_empty_i | input | 1 | Selected register tagged empty |
| inv_mask_i | input | 1 | Invalid exception masked (1) |
| done_o | output | 1 | Result valid pulse |
| flags_o | output | 3 | {ZF,PF,CF} |
| invalid_o | output | 1 | Invalid-operand indication |
| c1_clr_o | output | 1 | Stack underflow: clear C1 |
| pop_o | output | 1 | Pop request |

## Verification
The assertions assume that opcode_i and inv_mask_i stay meaningful only in start cycles. They also assume that done_o follows only from a start, so the checks sample the start-cycle inputs through $past. The directed stimulus holds every input at zero outside the one-cycle start strobe and never issues back-to-back starts. Each result is therefore tied to a single launch, and the hold rule for unrecognised opcodes can be observed on the flag outputs.

// File: rtl/fcf_pkg.sv
package fcf_pkg;
  parameter int EXP_W = 15;
  parameter int SIG_W = 64;
  localparam int FP_W = 1 + EXP_W + SIG_W;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [SIG_W-1:0] sig;
  } fp_t;

  typedef struct packed {
    logic zero;
    logic qnan;
    logic snan;
    logic unsup;
  } fp_class_t;

  typedef enum logic [1:0] {CMP_GT, CMP_LT, CMP_EQ, CMP_UN} cmp_e;

  localparam logic [7:0] OP_NOPOP = 8'hDB;
  localparam logic [7:0] OP_POP   = 8'hDF;
  localparam logic [4:0] SEL_SIG  = 5'b11110;
  localparam logic [4:0] SEL_QUI  = 5'b11101;

  function automatic logic [2:0] cmp_to_flags(cmp_e c);
    case (c)
      CMP_GT:  return 3'b000;
      CMP_LT:  return 3'b001;
      CMP_EQ:  return 3'b100;
      default: return 3'b111;
    endcase
  endfunction
endpackage

// File: rtl/fcf_decode.sv
module fcf_decode
  import fcf_pkg::*;
(
  input  logic [15:0] opcode_i,
  output logic        legal_o,
  output logic        quiet_o,
  output logic        pop_var_o,
  output logic [2:0]  idx_o
);
  logic first_ok, sel_sig, sel_qui;

  always_comb begin
    first_ok  = (opcode_i[15:8] == OP_NOPOP) || (opcode_i[15:8] == OP_POP);
    sel_sig   = opcode_i[7:3] == SEL_SIG;
    sel_qui   = opcode_i[7:3] == SEL_QUI;
    legal_o   = first_ok && (sel_sig || sel_qui);
    quiet_o   = sel_qui;
    pop_var_o = opcode_i[15:8] == OP_POP;
    idx_o     = opcode_i[2:0];
  end
endmodule

// File: rtl/fcf_classify.sv
module fcf_classify
  import fcf_pkg::*;
(
  input  fp_t       op_i,
  output fp_class_t cls_o
);
  localparam logic [EXP_W-1:0] EXP_MAX = '1;

  logic exp_zero, exp_max, int_bit, frac_nz, quiet_bit;

  always_comb begin
    exp_zero  = op_i.exp == '0;
    exp_max   = op_i.exp == EXP_MAX;
    int_bit   = op_i.sig[SIG_W-1];
    frac_nz   = |op_i.sig[SIG_W-2:0];
    quiet_bit = op_i.sig[SIG_W-2];
    cls_o.zero  = exp_zero && !int_bit && !frac_nz;
    // nonzero exponent without explicit integer bit (incl. max exponent)
    cls_o.unsup = !exp_zero && !int_bit;
    cls_o.qnan  = exp_max && int_bit && frac_nz && quiet_bit;
    cls_o.snan  = exp_max && int_bit && frac_nz && !quiet_bit;
  end
endmodule

// File: rtl/fcf_order.sv
module fcf_order
  import fcf_pkg::*;
(
  input  fp_t       a_i,
  input  fp_t       b_i,
  input  fp_class_t a_cls_i,
  input  fp_class_t b_cls_i,
  output cmp_e      res_o
);
  localparam int MAG_W = EXP_W + SIG_W;

  logic [MAG_W-1:0] a_mag, b_mag;
  logic mag_gt, mag_lt;

  always_comb begin
    a_mag  = {a_i.exp, a_i.sig};
    b_mag  = {b_i.exp, b_i.sig};
    mag_gt = a_mag > b_mag;
    mag_lt = a_mag < b_mag;
    if (a_cls_i.zero && b_cls_i.zero) begin
      res_o = CMP_EQ;
    end else if (a_i.sign != b_i.sign) begin
      res_o = a_i.sign ? CMP_LT : CMP_GT;
    end else if (!mag_gt && !mag_lt) begin
      res_o = CMP_EQ;
    end else if (mag_gt ^ a_i.sign) begin
      res_o = CMP_GT;
    end else begin
      res_o = CMP_LT;
    end
  end
endmodule

// File: rtl/fcf_unit.sv
module fcf_unit
  import fcf_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [15:0]     opcode_i,
  output logic [2:0]      src_idx_o,
  input  logic [FP_W-1:0] top_i,
  input  logic [FP_W-1:0] sti_i,
  input  logic            top_empty_i,
  input  logic            sti_empty_i,
  input  logic            inv_mask_i,
  output logic            done_o,
  output logic [2:0]      flags_o,
  output logic            invalid_o,
  output logic            c1_clr_o,
  output logic            pop_o
);
  localparam int N_OPS = 2;

  logic legal, quiet, pop_var;
  fp_t       ops [N_OPS];
  fp_class_t cls [N_OPS];
  logic [N_OPS-1:0] any_nan, hard_inv, quiet_nan;
  cmp_e ord_res;
  logic underflow, unordered, inv_nxt, pop_nxt;
  logic [2:0] flags_nxt;

  fcf_decode u_dec (
    .opcode_i (opcode_i),
    .legal_o  (legal),
    .quiet_o  (quiet),
    .pop_var_o(pop_var),
    .idx_o    (src_idx_o)
  );

  assign ops[0] = fp_t'(top_i);
  assign ops[1] = fp_t'(sti_i);

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fcf_classify u_cls (
      .op_i (ops[g]),
      .cls_o(cls[g])
    );
    assign any_nan[g]   = cls[g].qnan || cls[g].snan;
    assign quiet_nan[g] = cls[g].qnan;
    assign hard_inv[g]  = cls[g].snan || cls[g].unsup;
  end

  fcf_order u_ord (
    .a_i    (ops[0]),
    .b_i    (ops[1]),
    .a_cls_i(cls[0]),
    .b_cls_i(cls[1]),
    .res_o  (ord_res)
  );

  always_comb begin
    underflow = top_empty_i || sti_empty_i;
    unordered = underflow || (|any_nan) || cls[0].unsup || cls[1].unsup;
    inv_nxt   = underflow || (|hard_inv) || (!quiet && (|quiet_nan));
    flags_nxt = unordered ? cmp_to_flags(CMP_UN) : cmp_to_flags(ord_res);
    pop_nxt   = pop_var && !(inv_nxt && !inv_mask_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      flags_o   <= 3'b000;
      invalid_o <= 1'b0;
      c1_clr_o  <= 1'b0;
      pop_o     <= 1'b0;
    end else begin
      done_o <= start_i && legal;
      pop_o  <= start_i && legal && pop_nxt;
      if (start_i && legal) begin
        flags_o   <= flags_nxt;
        invalid_o <= inv_nxt;
        c1_clr_o  <= underflow;
      end
    end
  end
endmodule

// File: rtl/fcf_unit_chk.sv
module fcf_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [15:0] opcode_i,
  input logic        inv_mask_i,
  input logic        done_o,
  input logic [2:0]  flags_o,
  input logic        invalid_o,
  input logic        c1_clr_o,
  input logic        pop_o
);
  logic op_known;
  assign op_known = ((opcode_i[15:8] == 8'hDB) || (opcode_i[15:8] == 8'hDF)) &&
                    ((opcode_i[7:3] == 5'b11110) || (opcode_i[7:3] == 5'b11101));

  AST_DONE_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && op_known |=> done_o); // R1
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_i && op_known) |=> !done_o); // R1
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(flags_o)); // R1
  AST_FLAG_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (flags_o == 3'b000 || flags_o == 3'b001 ||
                flags_o == 3'b100 || flags_o == 3'b111)); // R2
  AST_INVALID_UNORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && invalid_o |-> flags_o == 3'b111); // R4
  AST_C1_WITH_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c1_clr_o |-> invalid_o && flags_o == 3'b111); // R7
  AST_POP_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i ##1 pop_o |-> done_o && $past(opcode_i[15:8]) == 8'hDF &&
    !(invalid_o && !$past(inv_mask_i))); // R8
  AST_POP_ONLY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> done_o); // R8
endmodule

bind fcf_unit fcf_unit_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .opcode_i  (opcode_i),
  .inv_mask_i(inv_mask_i),
  .done_o    (done_o),
  .flags_o   (flags_o),
  .invalid_o (invalid_o),
  .c1_clr_o  (c1_clr_o),
  .pop_o     (pop_o)
);

// File: tb/fcf_unit_tb.sv
module fcf_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] opcode_i = '0;
  logic [2:0]  src_idx_o;
  logic [79:0] top_i = '0, sti_i = '0;
  logic        top_empty_i = 1'b0, sti_empty_i = 1'b0, inv_mask_i = 1'b0;
  logic        done_o, invalid_o, c1_clr_o, pop_o;
  logic [2:0]  flags_o;

  int checks = 0, errors = 0;

  localparam logic [2:0] GT = 3'b000, LT = 3'b001, EQ = 3'b100, UN = 3'b111;

  always #4 clk_i = ~clk_i;

  fcf_unit u_dut (.*);

  function automatic logic [79:0] fp(logic s, logic [14:0] e, logic [63:0] m);
    return {s, e, m};
  endfunction

  localparam logic [63:0] M1 = 64'h8000_0000_0000_0000;
  logic [79:0] one, two, mone, mtwo, pz, nz, five, onep, inf, qnan, snan, unsup, pinf_bad;
  initial begin
    one  = fp(0, 15'h3FFF, M1);
    onep = fp(0, 15'h3FFF, 64'h8000_0000_0000_0001);
    two  = fp(0, 15'h4000, M1);
    five = fp(0, 15'h4001, 64'hA000_0000_0000_0000);
    mone = fp(1, 15'h3FFF, M1);
    mtwo = fp(1, 15'h4000, M1);
    pz   = '0;
    nz   = fp(1, 15'h0, 64'h0);
    inf  = fp(0, 15'h7FFF, M1);
    qnan = fp(0, 15'h7FFF, 64'hC000_0000_0000_0000);
    snan = fp(0, 15'h7FFF, 64'hA000_0000_0000_0000);
    unsup    = fp(0, 15'h3FFF, 64'h4000_0000_0000_0000);
    pinf_bad = fp(0, 15'h7FFF, 64'h0);
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic launch(logic [15:0] op, logic [79:0] a, logic [79:0] b,
                        logic ae, logic be, logic msk);
    @(negedge clk_i);
    opcode_i = op; top_i = a; sti_i = b;
    top_empty_i = ae; sti_empty_i = be; inv_mask_i = msk; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; opcode_i = '0; top_i = '0; sti_i = '0;
    top_empty_i = 1'b0; sti_empty_i = 1'b0; inv_mask_i = 1'b0;
  endtask

  task automatic cmp(string req, logic [15:0] op, logic [79:0] a, logic [79:0] b,
                     logic ae, logic be, logic msk,
                     logic [2:0] ef, logic ei, logic ec, logic ep);
    launch(op, a, b, ae, be, msk);
    chk({req, " done"}, done_o, 1);
    chk({req, " flags"}, flags_o, ef);
    chk({req, " invalid"}, invalid_o, ei);
    chk({req, " c1"}, c1_clr_o, ec);
    chk({req, " pop"}, pop_o, ep);
    @(negedge clk_i);
    chk({req, " done pulse"}, done_o, 0);
    chk({req, " pop pulse"}, pop_o, 0);
  endtask

  task automatic t_reset;
    chk("R10 done", done_o, 0);
    chk("R10 flags", flags_o, 0);
    chk("R10 invalid", invalid_o, 0);
    chk("R10 c1", c1_clr_o, 0);
    chk("R10 pop", pop_o, 0);
  endtask

  task automatic t_ordered;
    cmp("R2 gt exp", 16'hDBF1, two, one, 0, 0, 1, GT, 0, 0, 0);
    cmp("R2 lt exp", 16'hDBF1, one, two, 0, 0, 1, LT, 0, 0, 0);
    cmp("R2 eq", 16'hDBF2, five, five, 0, 0, 1, EQ, 0, 0, 0);
    cmp("R2 sig", 16'hDBE9, onep, one, 0, 0, 1, GT, 0, 0, 0);
    cmp("R2 neg rev", 16'hDBF1, mtwo, mone, 0, 0, 1, LT, 0, 0, 0);
    cmp("R2 neg rev2", 16'hDBF1, mone, mtwo, 0, 0, 1, GT, 0, 0, 0);
    cmp("R2 inf", 16'hDBF3, inf, five, 0, 0, 1, GT, 0, 0, 0);
  endtask

  task automatic t_sign;
    cmp("R3 sign", 16'hDBF1, mone, one, 0, 0, 1, LT, 0, 0, 0);
    cmp("R3 sign2", 16'hDBF1, one, mtwo, 0, 0, 1, GT, 0, 0, 0);
    cmp("R3 zero", 16'hDBF1, pz, nz, 0, 0, 1, EQ, 0, 0, 0);
    cmp("R3 nz vs pos", 16'hDBF1, nz, five, 0, 0, 1, LT, 0, 0, 0);
  endtask

  task automatic t_nan;
    cmp("R4 qnan", 16'hDBF0, one, qnan, 0, 0, 1, UN, 1, 0, 0);
    cmp("R4 snan", 16'hDBF0, snan, one, 0, 0, 1, UN, 1, 0, 0);
    cmp("R5 qnan quiet", 16'hDBE8, qnan, one, 0, 0, 1, UN, 0, 0, 0);
    cmp("R5 snan quiet", 16'hDBE8, one, snan, 0, 0, 1, UN, 1, 0, 0);
  endtask

  task automatic t_unsup;
    cmp("R6 sig", 16'hDBF1, unsup, one, 0, 0, 1, UN, 1, 0, 0);
    cmp("R6 quiet", 16'hDBE9, one, pinf_bad, 0, 0, 1, UN, 1, 0, 0);
  endtask

  task automatic t_empty;
    cmp("R7 empty b", 16'hDBE9, one, one, 0, 1, 1, UN, 1, 1, 0);
    cmp("R7 empty a", 16'hDBF4, one, one, 1, 0, 1, UN, 1, 1, 0);
  endtask

  task automatic t_pop;
    cmp("R8 pop ok", 16'hDFF1, two, one, 0, 0, 0, GT, 0, 0, 1);
    cmp("R8 pop unmasked", 16'hDFF1, qnan, one, 0, 0, 0, UN, 1, 0, 0);
    cmp("R8 pop masked", 16'hDFF1, qnan, one, 0, 0, 1, UN, 1, 0, 1);
    cmp("R8 quiet pop", 16'hDFE9, qnan, one, 0, 0, 0, UN, 0, 0, 1);
  endtask

  task automatic t_illegal;
    cmp("R1 prep", 16'hDBF1, one, two, 0, 0, 1, LT, 0, 0, 0);
    launch(16'hDBC1, two, one, 0, 0, 1);
    chk("R1 illegal done", done_o, 0);
    chk("R1 illegal flags", flags_o, LT);
    launch(16'hD9F1, qnan, one, 0, 0, 0);
    chk("R1 illegal byte done", done_o, 0);
    chk("R1 illegal byte inv", invalid_o, 0);
    chk("R1 illegal byte pop", pop_o, 0);
  endtask

  task automatic t_idx;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i);
      opcode_i = 16'hDFE8 | 16'(k);
      #1;
      chk("R9 idx", src_idx_o, k);
    end
    opcode_i = '0;
  endtask

  initial begin
    #1;
    t_reset();
    #20 rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_ordered();
    t_sign();
    t_nan();
    t_unsup();
    t_empty();
    t_pop();
    t_illegal();
    t_idx();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule